// File: doc/BRIEF.md
# PWM Event Action Qualifier

This block turns time-base events into two pulse-width-modulated waveforms. An external counter supplies its current value, its counting direction and one-tick strobes for "counter at zero" and "counter at period". The block holds two compare values and flags a match on each, telling a match while counting up from a match while counting down. That gives six event kinds per tick. Each of the two output channels has its own table that maps every event kind to an action: leave the level alone, drive it low, drive it high, or invert it.

Each compare value is written either straight into its active register or into a shadow copy that moves across when the counter reaches zero. A continuous software force per channel can pin a channel low or high for as long as it is active. The force code also has a shadow, and a selectable reload point decides when a new code takes over. When several events land in the same tick, a fixed priority picks a single action. A final output stage can drive the inverse of channel A onto the B pin, and it can exchange the two pins.

Top module: `pwm_action_qual`

## Requirements
- R1: Each channel's action table packs six 2-bit fields: bits [1:0] zero, [3:2] period, [5:4] compare-A up, [7:6] compare-A down, [9:8] compare-B up, [11:10] compare-B down. The action codes are 0 for no change, 1 for drive low, 2 for drive high and 3 for invert.
- R2: A zero event is `zero_i`. A period event is `prd_i`. A compare event occurs when `cnt_i` equals the active compare value, and it counts as "up" when `cnt_up_i`=1 and as "down" when it is 0. The channel level changes on the clock edge that samples the event.
- R3: When events coincide, the winner is the first of these that applies: software force, then compare-B events, then compare-A events, then period, then zero. An event whose action code is 0 does not mask an event of lower priority.
- R4: A compare value equal to 0 or to the period raises both its compare event and the zero or period event in the same tick, and R3 decides the result.
- R5: In shadow mode (`cmpX_imm_i`=0) a write lands in the shadow copy. The active compare value takes the shadow value on a tick with `zero_i`=1, and that tick still matches against the old value.
- R6: In immediate mode (`cmpX_imm_i`=1) a written compare value is matched from the next tick on.
- R7: Active force code 1 holds the channel low and code 2 holds it high, on every edge while the code is active. Codes 0 and 3 apply no force. When the force is released, the channel keeps its level until the next event.
- R8: `frc_ld_sel_i` chooses when a written force code becomes active: 0 on a zero tick, 1 on a period tick, 2 on either, 3 at the write edge. A code that becomes active at an edge first acts on the following edge.
- R9: With `inv_b_i`=1 the B pin carries the inverse of channel A.
- R10: With `swap_i`=1 the A and B pins are exchanged. The exchange is applied after the R9 selection.
- R11: Reset clears both channels, the compare values and the force codes. With R9 and R10 off, both pins are low.
- R12: In a tick with no event that has a non-zero action and no active force, the channel level holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | CNT_W | Time-base counter value |
| cnt_up_i | input | 1 | 1 while counting up, 0 while counting down |
| zero_i | input | 1 | Counter-at-zero strobe |
| prd_i | input | 1 | Counter-at-period strobe |
| cmpa_we_i | input | 1 | Compare A write strobe |
| cmpa_wdata_i | input | CNT_W | Compare A write value |
| cmpa_imm_i | input | 1 | Compare A immediate mode |
| cmpb_we_i | input | 1 | Compare B write strobe |
| cmpb_wdata_i | input | CNT_W | Compare B write value |
| cmpb_imm_i | input | 1 | Compare B immediate mode |
| act_a_i | input | 12 | Channel A action table |
| act_b_i | input | 12 | Channel B action table |
| frc_ld_sel_i | input | 2 | Force-code reload point |
| frc_a_we_i | input | 1 | Channel A force write strobe |
| frc_a_wdata_i | input | 2 | Channel A force code |
| frc_b_we_i | input | 1 | Channel B force write strobe |
| frc_b_wdata_i | input | 2 | Channel B force code |
| inv_b_i | input | 1 | Drive the inverse of channel A onto the B pin |
| swap_i | input | 1 | Exchange the A and B pins |
| pwm_a_o | output | 1 | Waveform A |
| pwm_b_o | output | 1 | Waveform B |

## Verification
The bench builds the block with an 8-bit counter width. A full up-down sweep with period 9 then fits in about twenty ticks, with both compare values and the turn-around points inside the sweep. Compare values of 0 and 9 place compare matches on the zero and period ticks, which exercises the priority rules. Short directed sequences cover the shadow-reload boundary of the compare and force registers and the order of the output stage.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

    localparam int NUM_EVT = 6;
    localparam int ACT_W   = 2 * NUM_EVT;

    // Event bit index; a higher index has higher priority
    localparam int EV_ZRO = 0;
    localparam int EV_PRD = 1;
    localparam int EV_CAU = 2;
    localparam int EV_CAD = 3;
    localparam int EV_CBU = 4;
    localparam int EV_CBD = 5;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_CLR  = 2'd1,
        ACT_SET  = 2'd2,
        ACT_TGL  = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        LD_ZERO   = 2'd0,
        LD_PRD    = 2'd1,
        LD_EITHER = 2'd2,
        LD_IMM    = 2'd3
    } ld_sel_e;

    localparam logic [1:0] FRC_OFF  = 2'd0;
    localparam logic [1:0] FRC_LOW  = 2'd1;
    localparam logic [1:0] FRC_HIGH = 2'd2;

endpackage

// File: rtl/pwm_aq_cmp.sv
module pwm_aq_cmp #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             imm_i,
    input  logic             zero_i,
    output logic [CNT_W-1:0] act_o
);

    typedef struct packed {
        logic [CNT_W-1:0] shadow;
        logic [CNT_W-1:0] active;
    } cmp_st_t;

    cmp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (imm_i) begin
            if (we_i) begin
                st_d.active = wdata_i;
                st_d.shadow = wdata_i;
            end
        end else begin
            if (zero_i) st_d.active = st_q.shadow;
            if (we_i)   st_d.shadow = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_o = st_q.active;

    assert_imm_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_i && we_i) |=> (act_o == $past(wdata_i)));

    assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_i && !zero_i) |=> $stable(act_o));

endmodule

// File: rtl/pwm_aq_frc.sv
module pwm_aq_frc
    import pwm_aq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we_i,
    input  logic [1:0] wdata_i,
    input  logic [1:0] ld_sel_i,
    input  logic       zero_i,
    input  logic       prd_i,
    output logic [1:0] code_o
);

    typedef struct packed {
        logic [1:0] shadow;
        logic [1:0] active;
    } frc_st_t;

    frc_st_t st_d, st_q;
    logic    reload;

    always_comb begin
        st_d = st_q;
        unique case (ld_sel_e'(ld_sel_i))
            LD_ZERO:   reload = zero_i;
            LD_PRD:    reload = prd_i;
            LD_EITHER: reload = zero_i | prd_i;
            default:   reload = 1'b0;
        endcase
        if (ld_sel_e'(ld_sel_i) == LD_IMM) begin
            if (we_i) begin
                st_d.active = wdata_i;
                st_d.shadow = wdata_i;
            end
        end else begin
            if (reload) st_d.active = st_q.shadow;
            if (we_i)   st_d.shadow = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code_o = st_q.active;

    assert_frc_zero_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_sel_i == LD_ZERO && !zero_i) |=> $stable(code_o));

    assert_frc_imm_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_sel_i == LD_IMM && we_i) |=> (code_o == $past(wdata_i)));

endmodule

// File: rtl/pwm_aq_chan.sv
module pwm_aq_chan
    import pwm_aq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [ACT_W-1:0]   tbl_i,
    input  logic [1:0]         frc_i,
    output logic               lvl_o
);

    typedef struct packed {
        logic lvl;
    } chan_st_t;

    chan_st_t st_d, st_q;
    act_e     pick;
    logic     live;

    always_comb begin
        st_d = st_q;
        pick = ACT_NONE;
        live = 1'b0;
        for (int k = 0; k < NUM_EVT; k++) begin
            if (evt_i[k] && (act_e'(tbl_i[2*k +: 2]) != ACT_NONE)) begin
                pick = act_e'(tbl_i[2*k +: 2]);
                live = 1'b1;
            end
        end
        unique case (pick)
            ACT_CLR: st_d.lvl = 1'b0;
            ACT_SET: st_d.lvl = 1'b1;
            ACT_TGL: st_d.lvl = ~st_q.lvl;
            default: st_d.lvl = st_q.lvl;
        endcase
        if (frc_i == FRC_LOW)  st_d.lvl = 1'b0;
        if (frc_i == FRC_HIGH) st_d.lvl = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o = st_q.lvl;

    assert_force_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frc_i == FRC_HIGH) |=> lvl_o);

    assert_force_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frc_i == FRC_LOW) |=> !lvl_o);

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!live && frc_i != FRC_LOW && frc_i != FRC_HIGH) |=> $stable(lvl_o));

endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             cnt_up_i,
    input  logic             zero_i,
    input  logic             prd_i,
    input  logic             cmpa_we_i,
    input  logic [CNT_W-1:0] cmpa_wdata_i,
    input  logic             cmpa_imm_i,
    input  logic             cmpb_we_i,
    input  logic [CNT_W-1:0] cmpb_wdata_i,
    input  logic             cmpb_imm_i,
    input  logic [11:0]      act_a_i,
    input  logic [11:0]      act_b_i,
    input  logic [1:0]       frc_ld_sel_i,
    input  logic             frc_a_we_i,
    input  logic [1:0]       frc_a_wdata_i,
    input  logic             frc_b_we_i,
    input  logic [1:0]       frc_b_wdata_i,
    input  logic             inv_b_i,
    input  logic             swap_i,
    output logic             pwm_a_o,
    output logic             pwm_b_o
);

    localparam int NUM_OUT = 2;
    localparam int NUM_CMP = 2;

    logic [NUM_CMP-1:0]            cmp_we;
    logic [NUM_CMP-1:0]            cmp_imm;
    logic [NUM_CMP-1:0][CNT_W-1:0] cmp_wdata;
    logic [NUM_CMP-1:0][CNT_W-1:0] cmp_act;
    logic [NUM_CMP-1:0]            cmp_hit;

    logic [NUM_OUT-1:0][ACT_W-1:0] tbl;
    logic [NUM_OUT-1:0]            frc_we;
    logic [NUM_OUT-1:0][1:0]       frc_wdata;
    logic [NUM_OUT-1:0][1:0]       frc_code;
    logic [NUM_OUT-1:0]            lvl;
    logic [NUM_EVT-1:0]            evt;
    logic                          b_sel;

    assign cmp_we    = {cmpb_we_i, cmpa_we_i};
    assign cmp_imm   = {cmpb_imm_i, cmpa_imm_i};
    assign cmp_wdata = {cmpb_wdata_i, cmpa_wdata_i};
    assign tbl       = {act_b_i, act_a_i};
    assign frc_we    = {frc_b_we_i, frc_a_we_i};
    assign frc_wdata = {frc_b_wdata_i, frc_a_wdata_i};

    for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
        pwm_aq_cmp #(.CNT_W(CNT_W)) cmp_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_i    (cmp_we[c]),
            .wdata_i (cmp_wdata[c]),
            .imm_i   (cmp_imm[c]),
            .zero_i  (zero_i),
            .act_o   (cmp_act[c])
        );
        assign cmp_hit[c] = (cnt_i == cmp_act[c]);
    end

    always_comb begin
        evt         = '0;
        evt[EV_ZRO] = zero_i;
        evt[EV_PRD] = prd_i;
        evt[EV_CAU] = cmp_hit[0] &  cnt_up_i;
        evt[EV_CAD] = cmp_hit[0] & ~cnt_up_i;
        evt[EV_CBU] = cmp_hit[1] &  cnt_up_i;
        evt[EV_CBD] = cmp_hit[1] & ~cnt_up_i;
    end

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        pwm_aq_frc frc_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .we_i     (frc_we[o]),
            .wdata_i  (frc_wdata[o]),
            .ld_sel_i (frc_ld_sel_i),
            .zero_i   (zero_i),
            .prd_i    (prd_i),
            .code_o   (frc_code[o])
        );
        pwm_aq_chan chan_i (
            .clk   (clk),
            .rst_n (rst_n),
            .evt_i (evt),
            .tbl_i (tbl[o]),
            .frc_i (frc_code[o]),
            .lvl_o (lvl[o])
        );
    end

    always_comb begin
        b_sel   = inv_b_i ? ~lvl[0] : lvl[1];
        pwm_a_o = swap_i ? b_sel  : lvl[0];
        pwm_b_o = swap_i ? lvl[0] : b_sel;
    end

    assert_inverse_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_b_i && !swap_i) |-> (pwm_b_o != pwm_a_o));

    assert_swap_pins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_i && !inv_b_i) |-> (pwm_a_o == lvl[1] && pwm_b_o == lvl[0]));

endmodule

// File: tb/pwm_action_qual_tb_top.sv
`timescale 1ns/100ps
module pwm_action_qual_tb_top;

    localparam int W = 8;
    localparam logic [11:0] ACT_A_DEF = 12'h096;
    localparam logic [11:0] ACT_B_DEF = 12'h929;

    // {cnt[7:0], up, zero, prd, expA, expB}
    localparam int NV = 20;
    localparam logic [12:0] VEC [0:NV-1] = '{
        {8'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {8'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        {8'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        {8'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'd6, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'd8, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'd9, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        {8'd8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'd6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
        {8'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
        {8'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
        {8'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {8'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] cnt = '0;
    logic cnt_up = 1'b1, zero = 1'b0, prd = 1'b0;
    logic cmpa_we = 1'b0, cmpa_imm = 1'b1, cmpb_we = 1'b0, cmpb_imm = 1'b1;
    logic [W-1:0] cmpa_wd = '0, cmpb_wd = '0;
    logic [11:0] act_a = ACT_A_DEF, act_b = ACT_B_DEF;
    logic [1:0] ld_sel = 2'd3;
    logic frc_a_we = 1'b0, frc_b_we = 1'b0;
    logic [1:0] frc_a_wd = '0, frc_b_wd = '0;
    logic inv_b = 1'b0, swap = 1'b0;
    logic pwm_a, pwm_b;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pwm_action_qual #(.CNT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .cnt_up_i(cnt_up),
        .zero_i(zero), .prd_i(prd),
        .cmpa_we_i(cmpa_we), .cmpa_wdata_i(cmpa_wd), .cmpa_imm_i(cmpa_imm),
        .cmpb_we_i(cmpb_we), .cmpb_wdata_i(cmpb_wd), .cmpb_imm_i(cmpb_imm),
        .act_a_i(act_a), .act_b_i(act_b), .frc_ld_sel_i(ld_sel),
        .frc_a_we_i(frc_a_we), .frc_a_wdata_i(frc_a_wd),
        .frc_b_we_i(frc_b_we), .frc_b_wdata_i(frc_b_wd),
        .inv_b_i(inv_b), .swap_i(swap),
        .pwm_a_o(pwm_a), .pwm_b_o(pwm_b)
    );

    task automatic step(input logic [W-1:0] c, input logic up, input logic z, input logic p);
        cnt = c; cnt_up = up; zero = z; prd = p;
        @(posedge clk);
        @(negedge clk);
        cmpa_we = 1'b0; cmpb_we = 1'b0; frc_a_we = 1'b0; frc_b_we = 1'b0;
        zero = 1'b0; prd = 1'b0;
    endtask

    task automatic chk(input string req, input logic ea, input logic eb);
        total++;
        if (pwm_a !== ea || pwm_b !== eb) begin
            bad++;
            $display("FAIL %s: a=%b b=%b expected a=%b b=%b", req, pwm_a, pwm_b, ea, eb);
        end
    endtask

    task automatic chk_a(input string req, input logic ea);
        total++;
        if (pwm_a !== ea) begin
            bad++;
            $display("FAIL %s: a=%b expected a=%b", req, pwm_a, ea);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 in reset", 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 after reset", 1'b0, 1'b0);

        // immediate compare setup: A=3, B=6 (R6)
        cmpa_wd = 8'd3; cmpa_we = 1'b1; cmpb_wd = 8'd6; cmpb_we = 1'b1;
        step(8'd1, 1'b1, 1'b0, 1'b0);
        chk("R6 setup hold", 1'b0, 1'b0);

        // R1 R2 R12: full up-down sweep with default tables
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][12:5], VEC[i][4], VEC[i][3], VEC[i][2]);
            chk($sformatf("R2 R1 R12 vector %0d", i), VEC[i][1], VEC[i][0]);
        end

        // R5: shadow compare reload on zero
        cmpa_imm = 1'b0; cmpa_wd = 8'd5; cmpa_we = 1'b1;
        step(8'd1, 1'b1, 1'b0, 1'b0);
        step(8'd5, 1'b1, 1'b0, 1'b0);
        chk("R5 shadow not yet active", 1'b1, 1'b0);
        step(8'd0, 1'b1, 1'b1, 1'b0);
        chk("R5 zero tick", 1'b1, 1'b0);
        step(8'd5, 1'b1, 1'b0, 1'b0);
        chk("R5 reloaded compare", 1'b0, 1'b1);

        // R4 R3: compare at zero
        cmpa_imm = 1'b1;
        step(8'd0, 1'b1, 1'b1, 1'b0);
        chk("R3 zero tick before compare write", 1'b1, 1'b0);
        cmpa_wd = 8'd0; cmpa_we = 1'b1;
        step(8'd1, 1'b1, 1'b0, 1'b0);
        step(8'd0, 1'b1, 1'b1, 1'b0);
        chk("R4 compare-A at zero wins", 1'b0, 1'b1);

        // R4 R3: compare-B at period
        cmpb_wd = 8'd9; cmpb_we = 1'b1;
        step(8'd1, 1'b1, 1'b0, 1'b0);
        step(8'd9, 1'b1, 1'b0, 1'b1);
        chk("R4 compare-B at period wins", 1'b0, 1'b0);

        // R1 toggle, R3 do-nothing does not mask
        act_a = 12'h003;
        step(8'd0, 1'b1, 1'b1, 1'b0);
        chk_a("R1 R3 toggle first", 1'b1);
        step(8'd0, 1'b1, 1'b1, 1'b0);
        chk_a("R1 R3 toggle second", 1'b0);
        act_a = ACT_A_DEF;

        // R7 R8: immediate force
        ld_sel = 2'd3;
        frc_a_wd = 2'd2; frc_a_we = 1'b1; frc_b_wd = 2'd1; frc_b_we = 1'b1;
        step(8'd1, 1'b1, 1'b0, 1'b0);
        step(8'd1, 1'b1, 1'b0, 1'b0);
        chk("R7 R8 force applied", 1'b1, 1'b0);
        step(8'd9, 1'b0, 1'b0, 1'b1);
        chk("R7 R3 force beats events", 1'b1, 1'b0);

        // R8: force reload on zero
        ld_sel = 2'd0;
        frc_a_wd = 2'd1; frc_a_we = 1'b1;
        step(8'd1, 1'b1, 1'b0, 1'b0);
        step(8'd1, 1'b1, 1'b0, 1'b0);
        chk_a("R8 shadow force not yet active", 1'b1);
        step(8'd0, 1'b1, 1'b1, 1'b0);
        chk_a("R8 zero tick uses old force", 1'b1);
        step(8'd1, 1'b1, 1'b0, 1'b0);
        chk_a("R8 new force active", 1'b0);

        // R7 release: level holds
        ld_sel = 2'd3;
        frc_a_wd = 2'd0; frc_a_we = 1'b1; frc_b_wd = 2'd0; frc_b_we = 1'b1;
        cmpa_wd = 8'd3; cmpa_we = 1'b1;
        step(8'd1, 1'b1, 1'b0, 1'b0);
        step(8'd1, 1'b1, 1'b0, 1'b0);
        chk("R7 R12 hold after release", 1'b0, 1'b0);
        step(8'd0, 1'b1, 1'b1, 1'b0);
        chk("R2 zero after release", 1'b1, 1'b0);

        // R10 R9 output stage
        swap = 1'b1; #1;
        chk("R10 swap", 1'b0, 1'b1);
        swap = 1'b0; inv_b = 1'b1; #1;
        chk("R9 inverse of A on B", 1'b1, 1'b0);
        swap = 1'b1; #1;
        chk("R10 R9 swap after inverse", 1'b0, 1'b1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule